// File: doc/BRIEF.md
# Dual Threshold Alarm Monitor

This block watches up to two of seven sensor channels and raises an alarm flag for each when a programmed condition holds. Every channel arrives as a 14-bit field on one of two parallel buses, one carrying unfiltered samples and one carrying filtered samples. A single strobe marks the cycle in which both buses hold a new sample set. Each alarm picks its channel, a level test or a rate-of-change test, and a comparison direction. All alarms share a choice between the filtered and the unfiltered bus.

Each alarm is driven by a small state machine. In `ST_OFF` the alarm has no valid source and its flag stays low. In `ST_FILL` a rate-of-change alarm stores samples until it holds enough history to compute a difference. In `ST_LIVE` the flag is re-evaluated on every strobe. A change to an alarm's configuration sends it to `ST_OFF` when the new source is invalid, to `ST_FILL` when the new mode is dynamic, and to `ST_LIVE` when the new mode is static. `ST_FILL` moves to `ST_LIVE` on the strobe that stores the N-th sample. Both flags drive one indicator signal. That signal has a programmable active level and can be steered to either of two output lines.

Top module: `dual_alarm`

## Requirements
- R1: Alarm 1 takes its source code from control bits 11:8 and alarm 2 from control bits 15:12. Codes 1, 2 and 3 pick gyro x, y and z. Codes 4, 5 and 6 pick accel x, y and z. Code 7 picks temperature. Code k reads bus bits [(k-1)*14 +: 14]. Codes 0 and 8 to 15 disable the alarm, and its flag then stays 0.
- R2: Control bit 6 sets the mode of alarm 1 and bit 7 sets the mode of alarm 2, where 1 means dynamic and 0 means static. A static alarm compares the current sample with the threshold.
- R3: Threshold bit 15 set to 1 triggers when the value is strictly greater than the threshold. Set to 0, it triggers when the value is strictly less. A value equal to the threshold never triggers.
- R4: Codes 1 to 6 are 14-bit two's complement, and the threshold is the sign-extended value of bits 13:0. For code 7 in static mode, both the sample and the threshold are 12-bit unsigned: sample bits 11:0 and threshold bits 11:0.
- R5: A dynamic alarm compares (current sample − the sample N strobes earlier) with the sign-extended threshold bits 13:0. N is the alarm's 8-bit count input, and the values 0 and 1 both mean N = 1.
- R6: A change to an alarm's source code, its mode bit, the filter bit or its count clears that alarm's flag in the next cycle. A sample strobed in the same cycle as such a change is discarded. A dynamic alarm then keeps its flag at 0 until N samples have been stored. Changing only the threshold does not restart this collection.
- R7: Control bit 4 set to 1 makes both alarms read the filtered bus. Set to 0, they read the unfiltered bus.
- R8: A flag takes its new value in the cycle after a strobe and holds it until the next strobe or configuration change.
- R9: Control bit 2 enables the indicator, bit 1 makes it active-high when 1, and bit 0 selects line 2 when 1 and line 1 when 0. The selected line shows the active level while the indicator is enabled and either flag is set. Otherwise it shows the inactive level. The drive output marks the selected line only while the indicator is enabled. The unselected line stays at 0.
- R10: Bit 0 of the flag output is alarm 1 and bit 1 is alarm 2.
- R11: After reset both flags are 0 and every alarm is in `ST_OFF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | New sample set valid on both buses |
| smp_raw | input | 98 | Seven unfiltered 14-bit channels |
| smp_filt | input | 98 | Seven filtered 14-bit channels |
| alm_ctrl | input | 16 | Source, mode, filter and indicator control |
| alm1_mag | input | 16 | Alarm 1 polarity (bit 15) and threshold |
| alm2_mag | input | 16 | Alarm 2 polarity (bit 15) and threshold |
| alm1_cnt | input | 8 | Alarm 1 dynamic sample distance |
| alm2_cnt | input | 8 | Alarm 2 dynamic sample distance |
| alm_flag | output | 2 | Alarm flags {alarm 2, alarm 1} |
| ind_level | output | 2 | Indicator level on lines {2, 1} |
| ind_drive | output | 2 | Line owned by the indicator {2, 1} |

## Verification
A stale history pointer or fill counter shows up as a flag that sets too early or too late after a configuration change. At a distance of 255 samples, the first flag that can rise is the one after the 256th strobe. A wrong state after a configuration change appears on the first strobe: a static alarm that stays silent, or a dynamic alarm that fires before its history is full. A wrong sign or zero extension flips the flag on samples near zero and near the top of the temperature range within one strobe. Indicator routing errors appear at the ports in the same cycle as the control change.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_FILL = 2'd1,
        ST_LIVE = 2'd2
    } alm_state_t;

endpackage

// File: rtl/alarm_src_sel.sv
module alarm_src_sel #(
    parameter int CH_W   = 14,
    parameter int TEMP_W = 12,
    parameter int N_CH   = 7,
    parameter int VAL_W  = CH_W + 2,
    parameter int BUS_W  = N_CH * CH_W
) (
    input  logic [3:0]              sel,
    input  logic                    use_filt,
    input  logic [BUS_W-1:0]        raw,
    input  logic [BUS_W-1:0]        filtd,
    output logic signed [VAL_W-1:0] val,
    output logic                    ok
);

    logic [BUS_W-1:0] word;
    logic [CH_W-1:0]  ch [N_CH];
    logic             unused_hi;

    assign word = use_filt ? filtd : raw;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        assign ch[g] = word[g*CH_W +: CH_W];
    end

    // upper bits of the temperature channel carry no data
    assign unused_hi = ^ch[N_CH-1][CH_W-1:TEMP_W];

    always_comb begin
        val = '0;
        ok  = 1'b0;
        for (int k = 0; k < N_CH; k++) begin
            if (sel == 4'(k + 1)) begin
                ok = 1'b1;
                if (k == N_CH - 1)
                    val = {{(VAL_W-TEMP_W){1'b0}}, ch[k][TEMP_W-1:0]};
                else
                    val = {{(VAL_W-CH_W){ch[k][CH_W-1]}}, ch[k]};
            end
        end
    end

endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
    import alarm_pkg::*;
#(
    parameter int CH_W   = 14,
    parameter int TEMP_W = 12,
    parameter int N_CH   = 7,
    parameter int CNT_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stb,
    input  logic [3:0]            sel,
    input  logic                  dyn,
    input  logic                  filt,
    input  logic [CNT_W-1:0]      n_cfg,
    input  logic                  thr_gt,
    input  logic [CH_W-1:0]       thr_raw,
    input  logic [N_CH*CH_W-1:0]  raw,
    input  logic [N_CH*CH_W-1:0]  filtd,
    output logic                  flag
);

    localparam int VAL_W = CH_W + 2;
    localparam int BUS_W = N_CH * CH_W;
    localparam int DEPTH = 1 << CNT_W;

    alm_state_t state, state_nx;

    logic signed [VAL_W-1:0] cur, old, diff, thr, cmp;
    logic                    src_ok;
    logic [3:0]              sel_q;
    logic                    dyn_q, filt_q;
    logic [CNT_W-1:0]        n_q, n_eff, wp, fill_cnt;
    logic                    cfg_chg, hist_we, hit;
    logic [VAL_W-1:0]        hist [DEPTH];

    alarm_src_sel #(
        .CH_W(CH_W), .TEMP_W(TEMP_W), .N_CH(N_CH), .VAL_W(VAL_W), .BUS_W(BUS_W)
    ) u_src (
        .sel(sel), .use_filt(filt), .raw(raw), .filtd(filtd),
        .val(cur), .ok(src_ok)
    );

    assign cfg_chg = ({sel, dyn, filt, n_cfg} != {sel_q, dyn_q, filt_q, n_q});
    assign n_eff   = (n_cfg > CNT_W'(1)) ? n_cfg : CNT_W'(1);

    // comparison datapath
    assign old  = hist[wp - n_eff];
    assign diff = cur - old;

    always_comb begin
        if (!dyn && sel == 4'(N_CH))
            thr = {{(VAL_W-TEMP_W){1'b0}}, thr_raw[TEMP_W-1:0]};
        else
            thr = {{(VAL_W-CH_W){thr_raw[CH_W-1]}}, thr_raw};
        cmp = dyn ? diff : cur;
        hit = thr_gt ? (cmp > thr) : (cmp < thr);
    end

    // next state
    always_comb begin
        state_nx = state;
        if (cfg_chg) begin
            if (!src_ok)
                state_nx = ST_OFF;
            else if (dyn)
                state_nx = ST_FILL;
            else
                state_nx = ST_LIVE;
        end else begin
            unique case (state)
                ST_OFF:  state_nx = ST_OFF;
                ST_FILL: if (stb && fill_cnt == n_eff - CNT_W'(1)) state_nx = ST_LIVE;
                ST_LIVE: state_nx = ST_LIVE;
                default: state_nx = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    assign hist_we = stb && !cfg_chg &&
                     (state == ST_FILL || (state == ST_LIVE && dyn));

    always_ff @(posedge clk) begin
        if (hist_we) hist[wp] <= cur;
    end

    // outputs, history bookkeeping and config snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag     <= 1'b0;
            wp       <= '0;
            fill_cnt <= '0;
            sel_q    <= '0;
            dyn_q    <= 1'b0;
            filt_q   <= 1'b0;
            n_q      <= '0;
        end else begin
            sel_q  <= sel;
            dyn_q  <= dyn;
            filt_q <= filt;
            n_q    <= n_cfg;
            if (cfg_chg) begin
                flag     <= 1'b0;
                wp       <= '0;
                fill_cnt <= '0;
            end else if (stb) begin
                unique case (state)
                    ST_OFF:  flag <= 1'b0;
                    ST_FILL: begin
                        flag     <= 1'b0;
                        fill_cnt <= fill_cnt + CNT_W'(1);
                    end
                    ST_LIVE: flag <= hit;
                    default: flag <= 1'b0;
                endcase
                if (hist_we) wp <= wp + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/alarm_ind.sv
module alarm_ind (
    input  logic [1:0] flags,
    input  logic       en,
    input  logic       act_hi,
    input  logic       line2,
    output logic [1:0] level,
    output logic [1:0] drive
);

    logic lvl;

    always_comb begin
        lvl   = (en && (|flags)) ? act_hi : !act_hi;
        level = line2 ? {lvl, 1'b0} : {1'b0, lvl};
        drive = en ? (line2 ? 2'b10 : 2'b01) : 2'b00;
    end

endmodule

// File: rtl/dual_alarm.sv
module dual_alarm #(
    parameter int CH_W   = 14,
    parameter int TEMP_W = 12,
    parameter int N_CH   = 7,
    parameter int CNT_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_stb,
    input  logic [N_CH*CH_W-1:0]  smp_raw,
    input  logic [N_CH*CH_W-1:0]  smp_filt,
    input  logic [15:0]           alm_ctrl,
    input  logic [15:0]           alm1_mag,
    input  logic [15:0]           alm2_mag,
    input  logic [CNT_W-1:0]      alm1_cnt,
    input  logic [CNT_W-1:0]      alm2_cnt,
    output logic [1:0]            alm_flag,
    output logic [1:0]            ind_level,
    output logic [1:0]            ind_drive
);

    localparam int N_ALM = 2;

    logic [15:0]      mag [N_ALM];
    logic [CNT_W-1:0] cnt [N_ALM];
    logic             unused_bits;

    assign mag[0] = alm1_mag;
    assign mag[1] = alm2_mag;
    assign cnt[0] = alm1_cnt;
    assign cnt[1] = alm2_cnt;
    assign unused_bits = ^{alm1_mag[14], alm2_mag[14], alm_ctrl[5], alm_ctrl[3]};

    for (genvar a = 0; a < N_ALM; a++) begin : g_alm
        alarm_unit #(
            .CH_W(CH_W), .TEMP_W(TEMP_W), .N_CH(N_CH), .CNT_W(CNT_W)
        ) u_unit (
            .clk    (clk),
            .rst_n  (rst_n),
            .stb    (smp_stb),
            .sel    (alm_ctrl[8 + 4*a +: 4]),
            .dyn    (alm_ctrl[6 + a]),
            .filt   (alm_ctrl[4]),
            .n_cfg  (cnt[a]),
            .thr_gt (mag[a][15]),
            .thr_raw(mag[a][CH_W-1:0]),
            .raw    (smp_raw),
            .filtd  (smp_filt),
            .flag   (alm_flag[a])
        );
    end

    alarm_ind u_ind (
        .flags (alm_flag),
        .en    (alm_ctrl[2]),
        .act_hi(alm_ctrl[1]),
        .line2 (alm_ctrl[0]),
        .level (ind_level),
        .drive (ind_drive)
    );

endmodule

// File: rtl/dual_alarm_chk.sv
module dual_alarm_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        smp_stb,
    input logic [15:0] alm_ctrl,
    input logic [1:0]  alm_flag,
    input logic [1:0]  ind_level,
    input logic [1:0]  ind_drive
);

    logic off1, off2;
    assign off1 = (alm_ctrl[11:8] == 4'd0) || (alm_ctrl[11:8] > 4'd7);
    assign off2 = (alm_ctrl[15:12] == 4'd0) || (alm_ctrl[15:12] > 4'd7);

    p_cfg_clear_a1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ({alm_ctrl[11:8], alm_ctrl[6], alm_ctrl[4]} !=
         $past({alm_ctrl[11:8], alm_ctrl[6], alm_ctrl[4]})) |=> !alm_flag[0]);

    p_cfg_clear_a2_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ({alm_ctrl[15:12], alm_ctrl[7], alm_ctrl[4]} !=
         $past({alm_ctrl[15:12], alm_ctrl[7], alm_ctrl[4]})) |=> !alm_flag[1]);

    p_sel_off_a1_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (off1 && $past(off1)) |-> !alm_flag[0]);

    p_sel_off_a2_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (off2 && $past(off2)) |-> !alm_flag[1]);

    p_rise_after_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(alm_flag[0]) || $rose(alm_flag[1])) |-> $past(smp_stb));

    p_drive_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ind_drive) && ((ind_drive != 2'b00) == alm_ctrl[2]));

    p_ind_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_ctrl[2] && (alm_flag != 2'b00)) |-> (ind_level[alm_ctrl[0]] == alm_ctrl[1]));

    p_ind_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_ctrl[2] || (alm_flag == 2'b00)) |-> (ind_level[alm_ctrl[0]] == !alm_ctrl[1]));

    p_other_line_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ind_level[!alm_ctrl[0]] == 1'b0);

endmodule

bind dual_alarm dual_alarm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .alm_ctrl(alm_ctrl),
    .alm_flag(alm_flag), .ind_level(ind_level), .ind_drive(ind_drive)
);

// File: tb/dual_alarm_tb.sv
`timescale 1ns/1ps
module dual_alarm_tb;

    localparam int BUS_W = 98;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             smp_stb = 1'b0;
    logic [BUS_W-1:0] smp_raw = '0;
    logic [BUS_W-1:0] smp_filt = '0;
    logic [15:0]      alm_ctrl = '0;
    logic [15:0]      alm1_mag = '0;
    logic [15:0]      alm2_mag = '0;
    logic [7:0]       alm1_cnt = '0;
    logic [7:0]       alm2_cnt = '0;
    logic [1:0]       alm_flag, ind_level, ind_drive;

    int n_chk = 0;
    int n_fail = 0;
    int hist_m [2][256];
    int col [2];
    bit expf [2];
    logic [13:0] pcfg [2];

    always #4 clk = ~clk;

    dual_alarm u_dut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_raw(smp_raw),
        .smp_filt(smp_filt), .alm_ctrl(alm_ctrl), .alm1_mag(alm1_mag),
        .alm2_mag(alm2_mag), .alm1_cnt(alm1_cnt), .alm2_cnt(alm2_cnt),
        .alm_flag(alm_flag), .ind_level(ind_level), .ind_drive(ind_drive)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int fmt(input int sel, input logic [BUS_W-1:0] bus);
        logic [13:0] w;
        w = bus[(sel-1)*14 +: 14];
        if (sel == 7) return int'(w[11:0]);
        return int'($signed(w));
    endfunction

    function automatic int thr_of(input int sel, input bit dyn, input logic [15:0] m);
        logic signed [13:0] t;
        if (!dyn && sel == 7) return int'(m[11:0]);
        t = m[13:0];
        return int'(t);
    endfunction

    function automatic bit hit(input int v, input int t, input bit gt);
        return gt ? (v > t) : (v < t);
    endfunction

    function automatic logic [13:0] cfg_of(input int a);
        logic [7:0] n;
        n = (a == 0) ? alm1_cnt : alm2_cnt;
        return {alm_ctrl[8+4*a +: 4], alm_ctrl[6+a], alm_ctrl[4], n};
    endfunction

    function automatic logic [3:0] ind_exp();
        logic lvl;
        logic [1:0] lev, drv;
        lvl = (alm_ctrl[2] && (expf[0] || expf[1])) ? alm_ctrl[1] : !alm_ctrl[1];
        lev = alm_ctrl[0] ? {lvl, 1'b0} : {1'b0, lvl};
        drv = alm_ctrl[2] ? (alm_ctrl[0] ? 2'b10 : 2'b01) : 2'b00;
        return {drv, lev};
    endfunction

    // R6: a configuration change restarts the model's history
    task automatic sync_cfg();
        for (int a = 0; a < 2; a++) begin
            if (cfg_of(a) != pcfg[a]) begin
                col[a]  = 0;
                expf[a] = 1'b0;
                pcfg[a] = cfg_of(a);
            end
        end
    endtask

    task automatic model_step();
        for (int a = 0; a < 2; a++) begin
            int sel, n, v, t;
            bit dyn;
            logic [15:0] m;
            sel = int'(alm_ctrl[8+4*a +: 4]);
            dyn = alm_ctrl[6+a];
            m   = (a == 0) ? alm1_mag : alm2_mag;
            n   = int'((a == 0) ? alm1_cnt : alm2_cnt);
            if (n < 1) n = 1;
            if (sel == 0 || sel > 7) begin
                expf[a] = 1'b0;
            end else begin
                v = fmt(sel, alm_ctrl[4] ? smp_filt : smp_raw);
                t = thr_of(sel, dyn, m);
                if (!dyn) begin
                    expf[a] = hit(v, t, m[15]);
                end else begin
                    if (col[a] >= n) expf[a] = hit(v - hist_m[a][(col[a]-n) % 256], t, m[15]);
                    else             expf[a] = 1'b0;
                    hist_m[a][col[a] % 256] = v;
                    col[a]++;
                end
            end
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, int'(alm_flag[0]), int'(expf[0]));
        chk(tag, int'(alm_flag[1]), int'(expf[1]));
        chk("R9", int'({ind_drive, ind_level}), int'(ind_exp()));
    endtask

    task automatic apply(input logic [15:0] c, input logic [15:0] m1, input logic [15:0] m2,
                         input logic [7:0] n1, input logic [7:0] n2);
        alm_ctrl = c; alm1_mag = m1; alm2_mag = m2; alm1_cnt = n1; alm2_cnt = n2;
        sync_cfg();
        @(negedge clk);
    endtask

    task automatic pulse(input string tag);
        model_step();
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        check_all(tag);
    endtask

    task automatic set_ch(input bit filt, input int k, input int val);
        if (filt) smp_filt[k*14 +: 14] = 14'(val);
        else      smp_raw[k*14 +: 14]  = 14'(val);
    endtask

    task automatic rand_bus();
        for (int k = 0; k < 7; k++) begin
            smp_raw[k*14 +: 14]  = 14'($urandom);
            smp_filt[k*14 +: 14] = 14'($urandom);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [1:0] held;
        void'($urandom(32'd5107));
        for (int a = 0; a < 2; a++) begin
            col[a] = 0; expf[a] = 1'b0; pcfg[a] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", int'(alm_flag), 0);
        chk("R11", int'({ind_drive, ind_level}), int'(ind_exp()));

        // R3 strict compare, equality never triggers
        apply(16'h0100, 16'h8000 | 16'd100, 16'h0, 8'd0, 8'd0);
        set_ch(0, 0, 100);  pulse("R3");
        set_ch(0, 0, 101);  pulse("R3");
        chk("R3", int'(alm_flag[0]), 1);
        apply(16'h0100, 16'd100, 16'h0, 8'd0, 8'd0);
        set_ch(0, 0, 100);  pulse("R3");
        chk("R3", int'(alm_flag[0]), 0);
        set_ch(0, 0, 99);   pulse("R3");
        apply(16'h0100, 16'h3FFC, 16'h0, 8'd0, 8'd0);
        set_ch(0, 0, -5);   pulse("R3");
        chk("R3", int'(alm_flag[0]), 1);

        // R4 temperature unsigned versus signed channel
        apply(16'h0700, 16'h8001, 16'h0, 8'd0, 8'd0);
        set_ch(0, 6, 12'hFFF); pulse("R4");
        chk("R4", int'(alm_flag[0]), 1);
        apply(16'h0100, 16'h8001, 16'h0, 8'd0, 8'd0);
        set_ch(0, 0, 14'h3FFF); pulse("R4");
        chk("R4", int'(alm_flag[0]), 0);

        // R7 filter select
        apply(16'h0110, 16'h8000 | 16'd100, 16'h0, 8'd0, 8'd0);
        set_ch(0, 0, 500); set_ch(1, 0, 0); pulse("R7");
        chk("R7", int'(alm_flag[0]), 0);
        apply(16'h0100, 16'h8000 | 16'd100, 16'h0, 8'd0, 8'd0);
        pulse("R7");
        chk("R7", int'(alm_flag[0]), 1);

        // R8 flag holds between strobes
        held = alm_flag;
        rand_bus();
        repeat (3) @(negedge clk);
        chk("R8", int'(alm_flag), int'(held));

        // R1 source mapping and disabled codes
        for (int s = 1; s <= 7; s++) begin
            smp_raw = '0;
            set_ch(0, s-1, 50);
            apply(16'((s << 8) | (s << 12)), 16'h8000 | 16'd20, 16'h8000 | 16'd20, 8'd0, 8'd0);
            pulse("R1");
            chk("R1", int'(alm_flag), 3);
        end
        smp_raw = '0;
        apply(16'h0000, 16'hA000, 16'hA000, 8'd0, 8'd0);
        pulse("R1");
        chk("R1", int'(alm_flag), 0);
        apply(16'hC900, 16'hA000, 16'hA000, 8'd0, 8'd0);
        pulse("R1");
        chk("R1", int'(alm_flag), 0);
        // R10 bit positions
        apply(16'h3000, 16'hA000, 16'hA000, 8'd0, 8'd0);
        pulse("R10");
        chk("R10", int'(alm_flag), 2);

        // R5 dynamic with count 0 meaning one sample
        apply(16'h0140, 16'h8000 | 16'd15, 16'h0, 8'd0, 8'd0);
        set_ch(0, 0, 10); pulse("R6");
        set_ch(0, 0, 30); pulse("R5");
        chk("R5", int'(alm_flag[0]), 1);
        set_ch(0, 0, 40); pulse("R5");
        chk("R5", int'(alm_flag[0]), 0);

        // R5 / R6 longest distance on alarm 2
        apply(16'h2080, 16'h0, 16'h8000, 8'd0, 8'd255);
        for (int i = 0; i < 300; i++) begin
            set_ch(0, 1, i);
            pulse(i < 255 ? "R6" : "R5");
        end
        chk("R5", int'(alm_flag[1]), 1);

        // R6 threshold change keeps history, count change refills
        apply(16'h0140, 16'hA000, 16'h0, 8'd3, 8'd0);
        for (int i = 0; i < 4; i++) begin
            set_ch(0, 0, 7 * i);
            pulse("R6");
        end
        chk("R6", int'(alm_flag[0]), 1);
        apply(16'h0140, 16'h2000, 16'h0, 8'd3, 8'd0);
        pulse("R6");
        apply(16'h0140, 16'hA000, 16'h0, 8'd3, 8'd0);
        pulse("R6");
        chk("R6", int'(alm_flag[0]), 1);
        apply(16'h0140, 16'hA000, 16'h0, 8'd2, 8'd0);
        chk("R6", int'(alm_flag[0]), 0);
        pulse("R6");
        pulse("R6");
        pulse("R6");
        chk("R6", int'(alm_flag[0]), 1);

        // R6 sample in the cycle of a configuration change is discarded
        apply(16'h0100, 16'hA000, 16'h0, 8'd0, 8'd0);
        pulse("R6");
        alm_ctrl = 16'h0200;
        sync_cfg();
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        chk("R6", int'(alm_flag[0]), 0);
        check_all("R6");

        // R9 indicator in all control combinations
        apply(16'h0100, 16'hA000, 16'h0, 8'd0, 8'd0);
        pulse("R2");
        for (int b = 0; b < 8; b++) begin
            apply(16'h0100 | 16'(b), 16'hA000, 16'h0, 8'd0, 8'd0);
            check_all("R9");
        end
        apply(16'h0100, 16'h2000, 16'h0, 8'd0, 8'd0);
        pulse("R2");
        for (int b = 0; b < 8; b++) begin
            apply(16'h0100 | 16'(b), 16'h2000, 16'h0, 8'd0, 8'd0);
            check_all("R9");
        end

        // R2 / R5 random configurations
        for (int c = 0; c < 40; c++) begin
            logic [15:0] rc, m1, m2;
            rc = 16'($urandom);
            rc[11:8]  = 4'($urandom_range(0, 9));
            rc[15:12] = 4'($urandom_range(0, 9));
            m1 = {1'($urandom), 1'b0, 14'($urandom)};
            m2 = {1'($urandom), 1'b0, 14'($urandom)};
            apply(rc, m1, m2, 8'($urandom_range(0, 12)), 8'($urandom_range(0, 12)));
            for (int p = 0; p < 20; p++) begin
                rand_bus();
                pulse((rc[6] || rc[7]) ? "R5" : "R2");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule